// File: doc/BRIEF.md
# Mode-Configured Eight-Pin GPIO Port Registers

This block holds the control state of one eight-pin general-purpose I/O port and sits behind a small register bus with an address, a write strobe, a read strobe and byte-wide data. It has two addressable locations. One is a direction register: a set bit makes the matching pin an output and a clear bit makes it an input. The other is a data latch. The direction register drives the per-pin output enables, and the data latch drives the per-pin output values. Pin inputs pass through a two-stage synchronizer before any read path uses them.

A two-bit mode input is captured while the block is initialized. In modes 1 and 2, pin 6 is tied to output: its direction bit resets to 1 and cannot be cleared. In mode 3, and in mode 0, every direction bit resets to 0 and every bit can be written. The direction register cannot be read back, and a read of its address returns all ones. A read of the data address gives the latch for output pins and the synchronized pin level for input pins. Pin 6 is the exception and always reads its synchronized level.

Reset and hardware standby both initialize the block. While software standby is asserted the block ignores bus writes, so every pin that is set as an output keeps driving its value.

Top module: `gpio_port_regs`

## Requirements
- R1: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals the data latch. A write to the data address (addr=1) loads every latch bit except bit 6 on the edge where `wr_en` is sampled high.
- R2: A read of the direction address (addr=0) returns 8'hFF whatever the register holds.
- R3: In modes 2'b01 and 2'b10 the direction register initializes to 8'h40. Bit 6 stays 1 and ignores writes, and the other bits take the written value.
- R4: In modes 2'b11 and 2'b00 the direction register initializes to 8'h00, and a write to addr=0 loads all eight bits, bit 6 included.
- R5: A read of the data address returns, for each bit other than bit 6, the latch value when the bit's direction bit is 1 and the synchronized pin level when it is 0.
- R6: Bit 6 of a data read always returns the synchronized pin 6 level. Writes to latch bit 6 have no effect, and latch bit 6 (and so `pin_out[6]`) follows the synchronized pin 6 level.
- R7: While `rst` or `hw_stby` is high, the direction register takes its mode reset value and latch bits other than bit 6 clear to 0. The mode is captured at that time.
- R8: While `sw_stby` is high and `hw_stby` is low, bus writes are ignored and `pin_oe` and `pin_out` keep their values.
- R9: Suppose a change on `pin_in` is present before edge k. A read whose `rd_en` is sampled at edge k or k+1 returns the old level, and a read sampled at edge k+2 or later returns the new level.
- R10: `rd_data` updates on the edge after `rd_en` is sampled high and holds its value between reads. It is 8'h00 after reset.
- R11: A change on `mode` while neither `rst` nor `hw_stby` is high has no effect on which direction bit is fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby, initializes like reset |
| sw_stby | input | 1 | Software standby, freezes register contents |
| mode | input | 2 | Operating mode, captured at initialization |
| addr | input | 1 | Register select: 0 direction, 1 data |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
A wrong direction bit appears on `pin_oe` on the edge after the write that caused it, because `pin_oe` is the register itself. A corrupted latch bit appears on `pin_out` in the same way. The latch is seen through `rd_data` only for bits set as outputs, so the bench reads each pattern with both output and input direction settings. A wrong synchronizer depth appears only as a shifted read latency, and the bench catches it by reading one, two and three cycles after a pin edge. A mode captured at the wrong time appears once a later direction write tries to clear bit 6.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    MODE_ZERO   = 2'd0,
    MODE_EXP_A  = 2'd1,
    MODE_EXP_B  = 2'd2,
    MODE_SINGLE = 2'd3
  } port_mode_e;

  // Modes in which one pin is tied to output direction.
  function automatic logic mode_ties_pin(input logic [1:0] m);
    return (m == MODE_EXP_A) || (m == MODE_EXP_B);
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= pin_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
  import gpio_port_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int FIXED_BIT = 6
) (
  input  logic             clk,
  input  logic             init,
  input  logic [1:0]       mode_in,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] dir_q
);

  localparam logic [WIDTH-1:0] FIX_MASK = WIDTH'(1) << FIXED_BIT;

  logic tied_q;

  always_ff @(posedge clk) begin
    if (init) begin
      tied_q <= mode_ties_pin(mode_in);
      dir_q  <= mode_ties_pin(mode_in) ? FIX_MASK : '0;
    end else if (wr_stb) begin
      dir_q  <= tied_q ? (wr_data | FIX_MASK) : wr_data;
    end
  end

  AST_TIED_BIT_OUTPUT: assert property (@(posedge clk) disable iff (init)
    tied_q |-> dir_q[FIXED_BIT]); // R3

  AST_DIR_WRITE_FREE: assert property (@(posedge clk) disable iff (init)
    (wr_stb && !tied_q) |=> (dir_q == $past(wr_data))); // R4

endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
  parameter int WIDTH     = 8,
  parameter int FIXED_BIT = 6
) (
  input  logic             clk,
  input  logic             init,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] data_q
);

  localparam logic [WIDTH-1:0] WR_MASK = ~(WIDTH'(1) << FIXED_BIT);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic bit_q;
    if (b == FIXED_BIT) begin : g_follow
      always_ff @(posedge clk) begin
        bit_q <= pin_sync[b];
      end
    end else begin : g_latch
      always_ff @(posedge clk) begin
        if (init)        bit_q <= 1'b0;
        else if (wr_stb) bit_q <= wr_data[b];
      end
    end
    assign data_q[b] = bit_q;
  end

  AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (init)
    wr_stb |=> ((data_q & WR_MASK) == ($past(wr_data) & WR_MASK))); // R1

  AST_FOLLOW_PIN: assert property (@(posedge clk) disable iff (init)
    1'b1 |=> (data_q[FIXED_BIT] == $past(pin_sync[FIXED_BIT]))); // R6

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int          WIDTH       = 8,
  parameter int          FIXED_BIT   = 6,
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 1,
  parameter logic [0:0]  DIR_ADDR    = 1'b0,
  parameter logic [0:0]  DATA_ADDR   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  localparam logic [WIDTH-1:0] FIX_MASK = WIDTH'(1) << FIXED_BIT;

  logic             init;
  logic             wr_ok;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] latch_sel;
  logic [WIDTH-1:0] rd_mux;

  assign init  = rst | hw_stby;
  assign wr_ok = wr_en & ~sw_stby & ~init;

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .pin_async (pin_in),
    .pin_sync  (pin_sync)
  );

  gpio_dir_reg #(.WIDTH(WIDTH), .FIXED_BIT(FIXED_BIT)) u_dir (
    .clk     (clk),
    .init    (init),
    .mode_in (mode),
    .wr_stb  (wr_ok && (addr == DIR_ADDR)),
    .wr_data (wr_data),
    .dir_q   (dir_q)
  );

  gpio_data_reg #(.WIDTH(WIDTH), .FIXED_BIT(FIXED_BIT)) u_data (
    .clk      (clk),
    .init     (init),
    .wr_stb   (wr_ok && (addr == DATA_ADDR)),
    .wr_data  (wr_data),
    .pin_sync (pin_sync),
    .data_q   (data_q)
  );

  // Latch is returned only for output pins; the tied pin always reads its level.
  assign latch_sel = dir_q & ~FIX_MASK;

  always_comb begin
    if (addr == DATA_ADDR) rd_mux = (latch_sel & data_q) | (~latch_sel & pin_sync);
    else                   rd_mux = '1;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign pin_oe  = dir_q;
  assign pin_out = data_q;

  AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == DIR_ADDR) |=> (rd_data == '1)); // R2

  AST_HW_STBY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> ((pin_out & ~FIX_MASK) == '0)); // R7

  AST_SW_STBY_HOLDS: assert property (@(posedge clk) disable iff (rst || hw_stby)
    sw_stby |=> ($stable(pin_oe) && $stable(pin_out & ~FIX_MASK))); // R8

  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R10

endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hw_stby = 1'b0;
  logic       sw_stby = 1'b0;
  logic [1:0] mode = 2'd1;
  logic [0:0] addr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  gpio_port_regs u_dut (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby), .mode(mode),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    mode = m; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] dir, input logic [7:0] lat,
                                          input logic [7:0] pin);
    logic [7:0] sel = dir & 8'hBF;
    return (sel & lat) | (~sel & pin);
  endfunction

  task automatic t_reset_tied;
    pin_in = 8'h00;
    do_reset(2'd1);
    check("R3 reset oe mode1", pin_oe, 8'h40);
    check("R7 reset latch", pin_out & 8'hBF, 8'h00);
    check("R10 rd_data after reset", rd_data, 8'h00);
  endtask

  task automatic t_dir_readback;
    logic [7:0] v;
    bus_wr(1'b0, 8'h3C);
    bus_rd(1'b0, v);
    check("R2 dir read ones", v, 8'hFF);
  endtask

  task automatic t_tied_bit;
    bus_wr(1'b0, 8'h00);
    check("R3 bit6 stays set", pin_oe, 8'h40);
    bus_wr(1'b0, 8'h0F);
    check("R3 other bits written", pin_oe, 8'h4F);
    mode = 2'd3;
    @(negedge clk);
    bus_wr(1'b0, 8'h00);
    check("R11 mode change ignored", pin_oe, 8'h40);
  endtask

  task automatic t_free_mode;
    do_reset(2'd3);
    check("R4 reset oe mode3", pin_oe, 8'h00);
    bus_wr(1'b0, 8'hC3);
    check("R4 all bits writable", pin_oe, 8'hC3);
    do_reset(2'd0);
    check("R4 reset oe mode0", pin_oe, 8'h00);
    bus_wr(1'b0, 8'h40);
    check("R4 bit6 writable mode0", pin_oe, 8'h40);
  endtask

  task automatic t_read_mux;
    logic [7:0] v;
    do_reset(2'd3);
    pin_in = 8'h3C;
    bus_wr(1'b0, 8'hF0);
    bus_wr(1'b1, 8'hA5);
    check("R1 pin_out latch", pin_out, 8'hA5);
    repeat (3) @(negedge clk);
    bus_rd(1'b1, v);
    check("R5 mixed read", v, exp_read(8'hF0, 8'hA5, 8'h3C));
    pin_in = 8'h7C;
    repeat (4) @(negedge clk);
    bus_rd(1'b1, v);
    check("R6 bit6 reads pin", v, exp_read(8'hF0, 8'hA5, 8'h7C));
    check("R6 latch bit6 follows pin", pin_out, 8'hE5);
    pin_in = 8'h3C;
    repeat (4) @(negedge clk);
    bus_wr(1'b1, 8'h40);
    check("R6 bit6 write ignored", pin_out, 8'h00);
    bus_wr(1'b0, 8'h00);
    bus_rd(1'b1, v);
    check("R5 all inputs read pins", v, 8'h3C);
    pin_in = 8'h55;
    repeat (4) @(negedge clk);
    check("R10 rd_data holds", rd_data, 8'h3C);
  endtask

  task automatic t_latency;
    logic [7:0] v0, v1, v2;
    do_reset(2'd3);
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    pin_in = 8'hFF;
    bus_rd(1'b1, v0);
    bus_rd(1'b1, v1);
    bus_rd(1'b1, v2);
    check("R9 read at edge k", v0, 8'h00);
    check("R9 read at edge k+1", v1, 8'h00);
    check("R9 read at edge k+2", v2, 8'hFF);
  endtask

  task automatic t_sw_stby;
    do_reset(2'd3);
    pin_in = 8'h00;
    bus_wr(1'b0, 8'h0F);
    bus_wr(1'b1, 8'h05);
    sw_stby = 1'b1;
    bus_wr(1'b0, 8'hF0);
    bus_wr(1'b1, 8'hFA);
    repeat (2) @(negedge clk);
    check("R8 oe held", pin_oe, 8'h0F);
    check("R8 out held", pin_out, 8'h05);
    sw_stby = 1'b0;
    bus_wr(1'b1, 8'h0A);
    check("R1 write after sw standby", pin_out, 8'h0A);
  endtask

  task automatic t_hw_stby;
    hw_stby = 1'b1;
    @(negedge clk);
    hw_stby = 1'b0;
    check("R7 hw standby oe mode3", pin_oe, 8'h00);
    check("R7 hw standby latch", pin_out & 8'hBF, 8'h00);
    do_reset(2'd2);
    bus_wr(1'b0, 8'h81);
    bus_wr(1'b1, 8'h81);
    hw_stby = 1'b1;
    @(negedge clk);
    hw_stby = 1'b0;
    check("R7 hw standby oe mode2", pin_oe, 8'h40);
    check("R7 hw standby latch mode2", pin_out & 8'hBF, 8'h00);
  endtask

  initial begin
    t_reset_tied();
    t_dir_readback();
    t_tied_bit();
    t_free_mode();
    t_read_mux();
    t_latency();
    t_sw_stby();
    t_hw_stby();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule